// File: doc/BRIEF.md
# DMA Global Control and Request Router

This block is the shared front end of a two-channel DMA controller. It holds a small register file on a simple synchronous bus: a write takes effect at the clock edge where the write strobe is high, and read data is a combinational function of the address. From that register file it drives one clock-enable line per channel engine. It also drives a global soft-reset pulse that returns the engines' sequencers and pointers to idle without touching any configuration.

Six peripheral request lines come in. Each has a 2-bit select field that sends it to channel 0, to channel 1 or to no channel. Receive-type peripherals feed a channel's source-side request, and transmit-type peripherals feed its destination-side request. The two channel interrupt lines can be read back live through a read-only status word.

Top module: `dma_front_ctrl`

## Requirements
- R1: After reset every register reads 0 at offsets 0x0, 0x4 and 0xC (with both interrupt inputs low), and chClkEn, chSrcReq, chDstReq and engSoftRst are all 0.
- R2: Control register (offset 0x0) bits 9:8 are stored clock enables. Bit 8+n drives chClkEn[n] from the cycle after the write and reads back in place.
- R3: Writing the control register with bit 0 = 1 raises engSoftRst for exactly RST_CYCLES (default 4) cycles, starting in the cycle after the write. While the pulse is high, bit 0 reads 1, and afterwards it reads 0. Writing bit 0 = 0 starts no pulse.
- R4: The soft-reset pulse leaves the clock enables and the select register unchanged.
- R5: The select register (offset 0x4) holds six 2-bit fields at bits 1:0, 5:4, 9:8, 13:12, 17:16 and 21:20, serving periphReq[0] to periphReq[5] in that order. All other bits read 0 and ignore writes.
- R6: Field code 01 routes the peripheral to channel 0 and 10 routes it to channel 1. The peripherals at even indices 0, 2 and 4 are receive-type and drive chSrcReq. The odd indices 1, 3 and 5 are transmit-type and drive chDstReq.
- R7: Field codes 00 and 11 route the request nowhere.
- R8: When several fields of the same side select one channel, only the lowest-numbered such field's request reaches that channel. The others are ignored.
- R9: A channel's chSrcReq and chDstReq are 0 whenever its clock enable is 0.
- R10: Offset 0xC reads chIrq live in bits 1:0, with all other bits 0. Writes to 0xC change nothing.
- R11: Any other offset reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe, sampled at the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| periphReq | input | 6 | Peripheral DMA requests, index = select field number |
| chIrq | input | 2 | Channel interrupt lines |
| chSrcReq | output | 2 | Source-side request per channel |
| chDstReq | output | 2 | Destination-side request per channel |
| chClkEn | output | 2 | Per-channel clock enable |
| engSoftRst | output | 1 | Global engine soft-reset pulse |

## Verification
The router is driven from a vector table. Each row combines a select word, a clock-enable pair and a request pattern. Rows with a single active request per side show that receive and transmit fields land on the correct side and the correct channel. Rows where all requests are active but the codes are reserved separate code 11 from a live code. Pairs of rows with the same select word differ only in whether the lowest-numbered competing field or a higher one carries the request, which shows whether priority is applied or the requests are ORed. Rows that switch each enable off alone show the masking per channel.

// File: rtl/dma_front_pkg.sv
package dma_front_pkg;

  // which register the read mux returns
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_CTRL = 2'd1,
    RD_SEL  = 2'd2,
    RD_STAT = 2'd3
  } rdSrc_e;

  // strobes from bus decode to the datapath
  typedef struct packed {
    logic   wrCtrl;
    logic   wrSel;
    logic   rstStart;
    rdSrc_e rdSrc;
  } ctlStrobe_t;

endpackage

// File: rtl/dma_front_ctl.sv
module dma_front_ctl
  import dma_front_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CTRL_OFS   = 0,
  parameter int SEL_OFS    = 4,
  parameter int STAT_OFS   = 12,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              wrBit0,
  output ctlStrobe_t        strobe,
  output logic              rstActive
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] rstCnt;

  always_comb begin
    strobe.wrCtrl   = regWrEn && (regAddr == CTRL_A);
    strobe.wrSel    = regWrEn && (regAddr == SEL_A);
    strobe.rstStart = strobe.wrCtrl && wrBit0;
    unique case (regAddr)
      CTRL_A:  strobe.rdSrc = RD_CTRL;
      SEL_A:   strobe.rdSrc = RD_SEL;
      STAT_A:  strobe.rdSrc = RD_STAT;
      default: strobe.rdSrc = RD_NONE;
    endcase
  end

  // soft reset sequencer: reload on start, count down to idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rstCnt <= '0;
    else if (strobe.rstStart) rstCnt <= CNT_W'(RST_CYCLES);
    else if (rstCnt != '0)    rstCnt <= rstCnt - 1'b1;
  end

  assign rstActive = (rstCnt != '0);

endmodule

// File: rtl/dma_front_route.sv
module dma_front_route #(
  parameter int                  NUM_CH     = 2,
  parameter int                  NUM_PERIPH = 6,
  parameter logic [NUM_PERIPH-1:0] TX_MASK  = 6'b101010
) (
  input  logic [2*NUM_PERIPH-1:0] selFlat,
  input  logic [NUM_PERIPH-1:0]   periphReq,
  input  logic [NUM_CH-1:0]       chEn,
  output logic [NUM_CH-1:0]       srcReq,
  output logic [NUM_CH-1:0]       dstReq
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [1:0] MY_CODE = 2'(c + 1);
    logic chSrc, chDst;

    // lowest-numbered matching field per side wins
    always_comb begin
      logic srcFound, dstFound;
      srcFound = 1'b0;
      dstFound = 1'b0;
      chSrc    = 1'b0;
      chDst    = 1'b0;
      for (int k = 0; k < NUM_PERIPH; k++) begin
        if (selFlat[2*k +: 2] == MY_CODE) begin
          if (TX_MASK[k]) begin
            if (!dstFound) begin
              chDst    = periphReq[k];
              dstFound = 1'b1;
            end
          end else begin
            if (!srcFound) begin
              chSrc    = periphReq[k];
              srcFound = 1'b1;
            end
          end
        end
      end
    end

    assign srcReq[c] = chSrc & chEn[c];
    assign dstReq[c] = chDst & chEn[c];
  end

endmodule

// File: rtl/dma_front_dp.sv
module dma_front_dp
  import dma_front_pkg::*;
#(
  parameter int                    DATA_W     = 32,
  parameter int                    NUM_CH     = 2,
  parameter int                    NUM_PERIPH = 6,
  parameter int                    SEL_STRIDE = 4,
  parameter int                    CLKEN_LSB  = 8,
  parameter logic [NUM_PERIPH-1:0] TX_MASK    = 6'b101010
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              rstActive,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_CH-1:0] chIrq,
  output logic [DATA_W-1:0] regRdData,
  output logic [NUM_CH-1:0] chClkEn,
  output logic [NUM_CH-1:0] chSrcReq,
  output logic [NUM_CH-1:0] chDstReq
);

  localparam int SEL_BITS = 2 * NUM_PERIPH;

  logic [NUM_CH-1:0]   clkEnQ;
  logic [SEL_BITS-1:0] selQ;
  logic [DATA_W-1:0]   ctrlWord, selWord, statWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkEnQ <= '0;
      selQ   <= '0;
    end else begin
      if (strobe.wrCtrl) clkEnQ <= regWrData[CLKEN_LSB +: NUM_CH];
      if (strobe.wrSel) begin
        for (int k = 0; k < NUM_PERIPH; k++)
          selQ[2*k +: 2] <= regWrData[k*SEL_STRIDE +: 2];
      end
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = rstActive;
    ctrlWord[CLKEN_LSB +: NUM_CH] = clkEnQ;
    selWord = '0;
    for (int k = 0; k < NUM_PERIPH; k++)
      selWord[k*SEL_STRIDE +: 2] = selQ[2*k +: 2];
    statWord = '0;
    statWord[NUM_CH-1:0] = chIrq;
  end

  always_comb begin
    unique case (strobe.rdSrc)
      RD_CTRL: regRdData = ctrlWord;
      RD_SEL:  regRdData = selWord;
      RD_STAT: regRdData = statWord;
      default: regRdData = '0;
    endcase
  end

  assign chClkEn = clkEnQ;

  dma_front_route #(
    .NUM_CH    (NUM_CH),
    .NUM_PERIPH(NUM_PERIPH),
    .TX_MASK   (TX_MASK)
  ) u_route (
    .selFlat  (selQ),
    .periphReq(periphReq),
    .chEn     (clkEnQ),
    .srcReq   (chSrcReq),
    .dstReq   (chDstReq)
  );

endmodule

// File: rtl/dma_front_ctrl.sv
module dma_front_ctrl
  import dma_front_pkg::*;
#(
  parameter int                    ADDR_W     = 4,
  parameter int                    DATA_W     = 32,
  parameter int                    NUM_CH     = 2,
  parameter int                    NUM_PERIPH = 6,
  parameter int                    SEL_STRIDE = 4,
  parameter int                    CLKEN_LSB  = 8,
  parameter int                    RST_CYCLES = 4,
  parameter logic [NUM_PERIPH-1:0] TX_MASK    = 6'b101010
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_CH-1:0]     chIrq,
  output logic [NUM_CH-1:0]     chSrcReq,
  output logic [NUM_CH-1:0]     chDstReq,
  output logic [NUM_CH-1:0]     chClkEn,
  output logic                  engSoftRst
);

  ctlStrobe_t strobe;
  logic       rstActive;

  dma_front_ctl #(
    .ADDR_W    (ADDR_W),
    .RST_CYCLES(RST_CYCLES)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .wrBit0   (regWrData[0]),
    .strobe   (strobe),
    .rstActive(rstActive)
  );

  dma_front_dp #(
    .DATA_W    (DATA_W),
    .NUM_CH    (NUM_CH),
    .NUM_PERIPH(NUM_PERIPH),
    .SEL_STRIDE(SEL_STRIDE),
    .CLKEN_LSB (CLKEN_LSB),
    .TX_MASK   (TX_MASK)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rstActive(rstActive),
    .regWrData(regWrData),
    .periphReq(periphReq),
    .chIrq    (chIrq),
    .regRdData(regRdData),
    .chClkEn  (chClkEn),
    .chSrcReq (chSrcReq),
    .chDstReq (chDstReq)
  );

  assign engSoftRst = rstActive;

endmodule

// File: rtl/dma_front_chk.sv
module dma_front_chk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int NUM_CH     = 2,
  parameter int NUM_PERIPH = 6,
  parameter int RST_CYCLES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regWrEn,
  input logic [DATA_W-1:0]     regWrData,
  input logic [DATA_W-1:0]     regRdData,
  input logic [NUM_PERIPH-1:0] periphReq,
  input logic [NUM_CH-1:0]     chIrq,
  input logic [NUM_CH-1:0]     chSrcReq,
  input logic [NUM_CH-1:0]     chDstReq,
  input logic [NUM_CH-1:0]     chClkEn,
  input logic                  engSoftRst
);

  localparam int AGE_W = $clog2(RST_CYCLES + 2) + 1;

  logic             startWr, ctrlWr;
  logic [AGE_W-1:0] pulseAge;

  assign ctrlWr  = regWrEn && (regAddr == '0);
  assign startWr = ctrlWr && regWrData[0];

  // cycles spent high since the most recent start write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   pulseAge <= '0;
    else if (startWr)                            pulseAge <= '0;
    else if (engSoftRst && pulseAge < AGE_W'(RST_CYCLES)) pulseAge <= pulseAge + 1'b1;
  end

  assert_rst_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    startWr |=> engSoftRst);

  assert_rst_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    engSoftRst |-> pulseAge < AGE_W'(RST_CYCLES));

  assert_cfg_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (engSoftRst && !ctrlWr) |=> $stable(chClkEn));

  assert_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((chSrcReq | chDstReq) & ~chClkEn) == '0);

  assert_src_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (chSrcReq != '0) |-> (periphReq[0] || periphReq[2] || periphReq[4]));

  assert_dst_origin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (chDstReq != '0) |-> (periphReq[1] || periphReq[3] || periphReq[5]));

  assert_status_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(12)) |-> (regRdData == DATA_W'(chIrq)));

endmodule

bind dma_front_ctrl dma_front_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_CH    (NUM_CH),
  .NUM_PERIPH(NUM_PERIPH),
  .RST_CYCLES(RST_CYCLES)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .periphReq (periphReq),
  .chIrq     (chIrq),
  .chSrcReq  (chSrcReq),
  .chDstReq  (chDstReq),
  .chClkEn   (chClkEn),
  .engSoftRst(engSoftRst)
);

// File: tb/dma_front_ctrl_tb.sv
`timescale 1ns/1ps
module dma_front_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [5:0]  periphReq = '0;
  logic [1:0]  chIrq = '0;
  logic [1:0]  chSrcReq, chDstReq, chClkEn;
  logic        engSoftRst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_front_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .periphReq(periphReq),
    .chIrq(chIrq), .chSrcReq(chSrcReq), .chDstReq(chDstReq),
    .chClkEn(chClkEn), .engSoftRst(engSoftRst)
  );

  typedef struct packed {
    logic [31:0] sel;
    logic [1:0]  en;
    logic [5:0]  req;
    logic [1:0]  src;
    logic [1:0]  dst;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0021, 2'b11, 6'h03, 2'b01, 2'b10},  // R6 SPI0 rx->ch0, tx->ch1
    '{32'h0000_0021, 2'b11, 6'h01, 2'b01, 2'b00},  // R6 rx only
    '{32'h0021_1200, 2'b11, 6'h3C, 2'b11, 2'b11},  // R6 upper fields
    '{32'h0021_1200, 2'b11, 6'h14, 2'b11, 2'b00},  // R6 receive-only pattern
    '{32'h0001_0101, 2'b11, 6'h14, 2'b00, 2'b00},  // R8 field0 wins, its req low
    '{32'h0001_0101, 2'b11, 6'h01, 2'b01, 2'b00},  // R8 field0 wins, req high
    '{32'h0000_0033, 2'b11, 6'h3F, 2'b00, 2'b00},  // R7 reserved code
    '{32'h0000_0021, 2'b01, 6'h03, 2'b01, 2'b00},  // R9 ch1 masked
    '{32'h0000_0021, 2'b10, 6'h03, 2'b00, 2'b10},  // R9 ch0 masked
    '{32'h0000_2020, 2'b11, 6'h08, 2'b00, 2'b00},  // R8 tx field1 wins over field3
    '{32'h0000_2020, 2'b11, 6'h02, 2'b00, 2'b10}   // R8 tx field1 req high
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int hi;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(4'h0, rd); check("R1 ctrl", rd, 0);
    busRead(4'h4, rd); check("R1 sel", rd, 0);
    busRead(4'hC, rd); check("R1 stat", rd, 0);
    check("R1 outputs", {25'd0, chClkEn, chSrcReq, chDstReq, engSoftRst}, 0);

    // R5 field layout, unused bits read 0
    busWrite(4'h4, 32'hFFFF_FFFF);
    busRead(4'h4, rd); check("R5 sel readback", rd, 32'h0033_3333);

    // R2 enables, written without reset bit
    busWrite(4'h0, 32'hFFFF_FFFE);
    busRead(4'h0, rd); check("R2 ctrl readback", rd, 32'h0000_0300);
    check("R2 chClkEn", {30'd0, chClkEn}, 2'b11);
    check("R3 no pulse on bit0=0", {31'd0, engSoftRst}, 0);
    busWrite(4'h0, 32'h0000_0100);
    check("R2 chClkEn ch0 only", {30'd0, chClkEn}, 2'b01);

    // vector walk over the router
    for (int i = 0; i < NV; i++) begin
      busWrite(4'h4, VECS[i].sel);
      busWrite(4'h0, {22'd0, VECS[i].en, 8'd0});
      periphReq = VECS[i].req;
      #0.5;
      check($sformatf("R6/R7/R8/R9 vec%0d src", i), {30'd0, chSrcReq}, {30'd0, VECS[i].src});
      check($sformatf("R6/R7/R8/R9 vec%0d dst", i), {30'd0, chDstReq}, {30'd0, VECS[i].dst});
    end
    periphReq = '0;

    // R3 soft reset pulse and R4 configuration kept
    busWrite(4'h4, 32'h0021_1200);
    busWrite(4'h0, 32'h0000_0301);
    busRead(4'h0, rd); check("R3 bit0 reads 1 during pulse", rd, 32'h0000_0301);
    hi = 0;
    for (int i = 0; i < 8; i++) begin
      if (engSoftRst) hi++;
      @(negedge clk);
    end
    check("R3 pulse length", hi, 4);
    busRead(4'h0, rd); check("R3 R4 ctrl after pulse", rd, 32'h0000_0300);
    busRead(4'h4, rd); check("R4 sel kept", rd, 32'h0021_1200);
    check("R4 chClkEn kept", {30'd0, chClkEn}, 2'b11);

    // R10 live status, write ignored
    chIrq = 2'b10;
    busRead(4'hC, rd); check("R10 stat 10", rd, 2);
    busWrite(4'hC, 32'hFFFF_FFFF);
    busRead(4'hC, rd); check("R10 stat after write", rd, 2);
    chIrq = 2'b01;
    busRead(4'hC, rd); check("R10 stat 01", rd, 1);
    busRead(4'h0, rd); check("R10 write to 0xC left ctrl", rd, 32'h0000_0300);

    // R11 unmapped offset
    busWrite(4'h8, 32'hFFFF_FFFF);
    busRead(4'h8, rd); check("R11 unmapped read", rd, 0);
    busRead(4'h4, rd); check("R11 sel untouched", rd, 32'h0021_1200);
    busRead(4'h0, rd); check("R11 ctrl untouched", rd, 32'h0000_0300);
    check("R11 no pulse", {31'd0, engSoftRst}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule